// File: doc/BRIEF.md
# Snooping Line Coherence Controller

This block keeps the coherence state of a small set of cache lines on a snooping bus that distinguishes clean lines from lines this cache owns. Every line is in one of five states: invalid, clean-exclusive, owned-exclusive, clean-shared or owned-shared. A build-time switch adds a sixth, clean-owned-shared. In that state this cache answers reads of a clean line on behalf of memory. Requests come from the processor side and from the bus snooper. For each request the block reports three things one cycle later: the bus operation this cache must start, whether it supplies the data itself (intervention), and the state the line moves to.

The processor side is a valid/ready stream. A request must stay on `cpu_valid`/`cpu_op`/`cpu_line`/`shared_hit` until a cycle in which `cpu_ready` is high, and it is taken in that cycle. `cpu_ready` is low in two cases: while a snooped operation is present, because the snoop wins the cycle, and during the second, locked cycle of a fetch-and-increment. Snooped operations have no back-pressure and are taken in the cycle they appear. `shared_hit` is sampled together with a processor read. It tells the block whether another cache holds the line.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is invalid, all outputs are low and `cpu_ready` is high.
- R2: A processor read (cpu_op 0) of an invalid line issues a coherent read (bus op 1). The line becomes clean-exclusive (state 1) when `shared_hit` is low and clean-shared (state 3) when it is high.
- R3: A processor write (cpu_op 1) of an invalid line issues a read-and-invalidate (bus op 2) and the line becomes owned-exclusive (state 2).
- R4: In clean-exclusive a write moves to owned-exclusive with no bus operation. Reads of any valid line, and writes in owned-exclusive, issue nothing and keep the state.
- R5: A write in clean-shared, owned-shared (state 4) or clean-owned-shared (state 5) issues a coherent invalidate (bus op 3) and moves to owned-exclusive.
- R6: Replacing a line (cpu_op 2) always leaves it invalid (state 0). A write-back (bus op 4) is issued only from owned-exclusive or owned-shared.
- R7: In owned-exclusive or owned-shared, a snooped coherent read is answered by intervention and the line ends in owned-shared. A snooped read-and-invalidate is answered by intervention and the line ends invalid.
- R8: In clean-exclusive a snooped coherent read moves to clean-owned-shared with intervention when that state is built in. Otherwise it moves to clean-shared, and intervention follows the clean-exclusive supply switch. A snooped read-and-invalidate ends invalid with the same intervention rule.
- R9: In clean-owned-shared a snooped coherent read is answered by intervention and the state is kept. A read-and-invalidate is answered by intervention and ends invalid. A snooped invalidate ends invalid and a snooped write-back leaves the state unchanged.
- R10: A snooped write-invalidate (bus op 5) makes any valid line invalid. In clean-shared, a snooped read-and-invalidate or invalidate ends invalid, and a snooped read or write-back is ignored.
- R11: A snooped invalidate or write-back in clean-exclusive or owned-exclusive, or a snooped write-back in owned-shared, raises `proto_err` and leaves the state unchanged.
- R12: A fetch-and-increment (cpu_op 3) holds `bus_lock` for two output cycles and ends owned-exclusive. It issues a read-and-invalidate from invalid, clean-shared, owned-shared and clean-owned-shared, and nothing from an exclusive state. `cpu_ready` is low during the locked write cycle. A snoop arriving in that cycle raises `proto_err` and is ignored.
- R13: While `snp_valid` is high, `cpu_ready` is low. The snoop is handled in that cycle and the held processor request is taken in the next free cycle.
- R14: Every request is reported one cycle later with `upd_valid`, the line index and the resulting state. Snooped operations never issue a bus operation, and any snoop to an invalid line leaves it invalid with no intervention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Processor request taken this cycle |
| cpu_op | input | 2 | 0 read, 1 write, 2 replace, 3 fetch-and-increment |
| cpu_line | input | IDXW | Line index of the processor request |
| shared_hit | input | 1 | Another cache holds the line (sampled with a read) |
| snp_valid | input | 1 | Snooped bus operation present |
| snp_op | input | 3 | Snooped operation: 1 read, 2 read-and-invalidate, 3 invalidate, 4 write-back, 5 write-invalidate |
| snp_line | input | IDXW | Line index of the snooped operation |
| bus_req_valid | output | 1 | This cache must start a bus operation |
| bus_req_op | output | 3 | Bus operation to start, same encoding as snp_op |
| bus_lock | output | 1 | Bus held for an atomic sequence |
| intervene | output | 1 | This cache supplies the data |
| proto_err | output | 1 | Illegal snoop for the current state |
| upd_valid | output | 1 | A request was handled |
| upd_state | output | 3 | Resulting state: 0 I, 1 CE, 2 OE, 3 CS, 4 OS, 5 COS |
| upd_line | output | IDXW | Line the report refers to |

## Verification
The bench builds two copies with four lines each and drives them in lockstep. The first copy has the clean-owned-shared state and no supply from clean-exclusive. The second copy has no clean-owned-shared state and does supply from clean-exclusive. With this pair, both outcomes of a snooped read in clean-exclusive can be observed. Every reachable start state is set up on a rotating line and then hit with every processor and snoop operation. Separate sequences cover snoop-over-processor priority and a snoop that arrives inside the locked cycle of a fetch-and-increment.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_CEX = 3'd1,
    ST_OEX = 3'd2,
    ST_CSH = 3'd3,
    ST_OSH = 3'd4,
    ST_COS = 3'd5
  } line_st_e;

  typedef enum logic [1:0] {
    CPU_RD    = 2'd0,
    CPU_WR    = 2'd1,
    CPU_EVICT = 2'd2,
    CPU_FINC  = 2'd3
  } cpu_op_e;

  typedef enum logic [2:0] {
    BOP_NONE  = 3'd0,
    BOP_RD    = 3'd1,
    BOP_RDINV = 3'd2,
    BOP_INV   = 3'd3,
    BOP_WB    = 3'd4,
    BOP_WRINV = 3'd5
  } bus_op_e;

  typedef struct packed {
    line_st_e nxt;
    bus_op_e  op;
    logic     supply;
    logic     err;
  } xition_t;

endpackage

// File: rtl/coh_xition.sv
// Combinational transition function for one line.
module coh_xition
  import coh_pkg::*;
#(
  parameter bit HAS_COS     = 1'b1,
  parameter bit CE_SUPPLIES = 1'b0
)(
  input  line_st_e cur,
  input  logic     is_snoop,
  input  cpu_op_e  cop,
  input  bus_op_e  sop,
  input  logic     shared,
  output xition_t  res
);

  // Intervention from clean-exclusive on a snooped read
  localparam bit CE_GIVES = HAS_COS | CE_SUPPLIES;

  always_comb begin
    res.nxt    = cur;
    res.op     = BOP_NONE;
    res.supply = 1'b0;
    res.err    = 1'b0;
    if (!is_snoop) begin
      unique case (cop)
        CPU_RD: begin
          if (cur == ST_INV) begin
            res.op  = BOP_RD;
            res.nxt = shared ? ST_CSH : ST_CEX;
          end
        end
        CPU_WR, CPU_FINC: begin
          res.nxt = ST_OEX;
          case (cur)
            ST_INV:         res.op = BOP_RDINV;
            ST_CEX, ST_OEX: res.op = BOP_NONE;
            default:        res.op = (cop == CPU_FINC) ? BOP_RDINV : BOP_INV;
          endcase
        end
        CPU_EVICT: begin
          res.nxt = ST_INV;
          if (cur == ST_OEX || cur == ST_OSH) res.op = BOP_WB;
        end
        default: res.nxt = cur;
      endcase
    end else if (sop == BOP_WRINV) begin
      res.nxt = ST_INV;
    end else begin
      case (cur)
        ST_CEX: begin
          case (sop)
            BOP_RD: begin
              res.nxt    = HAS_COS ? ST_COS : ST_CSH;
              res.supply = CE_GIVES;
            end
            BOP_RDINV: begin
              res.nxt    = ST_INV;
              res.supply = CE_GIVES;
            end
            BOP_INV, BOP_WB: res.err = 1'b1;
            default: res.nxt = cur;
          endcase
        end
        ST_OEX: begin
          case (sop)
            BOP_RD: begin
              res.nxt    = ST_OSH;
              res.supply = 1'b1;
            end
            BOP_RDINV: begin
              res.nxt    = ST_INV;
              res.supply = 1'b1;
            end
            BOP_INV, BOP_WB: res.err = 1'b1;
            default: res.nxt = cur;
          endcase
        end
        ST_CSH: begin
          case (sop)
            BOP_RDINV, BOP_INV: res.nxt = ST_INV;
            default: res.nxt = cur;
          endcase
        end
        ST_OSH, ST_COS: begin
          case (sop)
            BOP_RD: res.supply = 1'b1;
            BOP_RDINV: begin
              res.nxt    = ST_INV;
              res.supply = 1'b1;
            end
            BOP_INV: res.nxt = ST_INV;
            BOP_WB:  res.err = (cur == ST_OSH);
            default: res.nxt = cur;
          endcase
        end
        default: res.nxt = cur;
      endcase
    end
  end

endmodule

// File: rtl/coh_state_store.sv
// Per-line state registers with one read and one write port.
module coh_state_store
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int IDXW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] rd_idx,
  output line_st_e        rd_st,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  line_st_e        wr_st
);

  line_st_e st_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              st_q[g] <= ST_INV;
      else if (wr_en && wr_idx == IDXW'(g))    st_q[g] <= wr_st;
    end
  end

  always_comb begin
    if (int'(rd_idx) < NUM_LINES) rd_st = st_q[rd_idx];
    else                          rd_st = ST_INV;
  end

endmodule

// File: rtl/coh_req_seq.sv
// Picks the request served each cycle and runs the locked second phase.
module coh_req_seq
  import coh_pkg::*;
#(
  parameter int IDXW = 2
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_valid,
  input  cpu_op_e         cpu_op,
  input  logic [IDXW-1:0] cpu_line,
  input  logic            snp_valid,
  output logic            cpu_ready,
  output logic            take_snoop,
  output logic            take_cpu,
  output logic            wr_phase,
  output logic [IDXW-1:0] lock_line
);

  logic            busy_q;
  logic [IDXW-1:0] line_q;

  assign cpu_ready  = !busy_q && !snp_valid;
  assign take_snoop = snp_valid && !busy_q;
  assign take_cpu   = cpu_valid && cpu_ready;
  assign wr_phase   = busy_q;
  assign lock_line  = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      line_q <= '0;
    end else begin
      busy_q <= take_cpu && (cpu_op == CPU_FINC);
      if (take_cpu) line_q <= cpu_line;
    end
  end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter bit HAS_COS     = 1'b1,
  parameter bit CE_SUPPLIES = 1'b0,
  localparam int IDXW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_valid,
  output logic            cpu_ready,
  input  logic [1:0]      cpu_op,
  input  logic [IDXW-1:0] cpu_line,
  input  logic            shared_hit,
  input  logic            snp_valid,
  input  logic [2:0]      snp_op,
  input  logic [IDXW-1:0] snp_line,
  output logic            bus_req_valid,
  output logic [2:0]      bus_req_op,
  output logic            bus_lock,
  output logic            intervene,
  output logic            proto_err,
  output logic            upd_valid,
  output logic [2:0]      upd_state,
  output logic [IDXW-1:0] upd_line
);

  logic            take_snoop, take_cpu, wr_phase;
  logic [IDXW-1:0] lock_line, ev_line;
  line_st_e        cur_st;
  xition_t         xr;
  cpu_op_e         cop;
  bus_op_e         sop;

  logic            ev_valid, ev_sup, ev_err, ev_lock;
  bus_op_e         ev_op;
  line_st_e        ev_nxt;

  assign cop = cpu_op_e'(cpu_op);
  assign sop = bus_op_e'(snp_op);

  coh_req_seq #(.IDXW(IDXW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_op     (cop),
    .cpu_line   (cpu_line),
    .snp_valid  (snp_valid),
    .cpu_ready  (cpu_ready),
    .take_snoop (take_snoop),
    .take_cpu   (take_cpu),
    .wr_phase   (wr_phase),
    .lock_line  (lock_line)
  );

  always_comb begin
    if (wr_phase)        ev_line = lock_line;
    else if (take_snoop) ev_line = snp_line;
    else                 ev_line = cpu_line;
  end

  coh_state_store #(.NUM_LINES(NUM_LINES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (ev_line),
    .rd_st  (cur_st),
    .wr_en  (ev_valid),
    .wr_idx (ev_line),
    .wr_st  (ev_nxt)
  );

  coh_xition #(.HAS_COS(HAS_COS), .CE_SUPPLIES(CE_SUPPLIES)) u_xition (
    .cur      (cur_st),
    .is_snoop (take_snoop),
    .cop      (cop),
    .sop      (sop),
    .shared   (shared_hit),
    .res      (xr)
  );

  always_comb begin
    ev_valid = 1'b0;
    ev_op    = BOP_NONE;
    ev_sup   = 1'b0;
    ev_err   = 1'b0;
    ev_lock  = 1'b0;
    ev_nxt   = cur_st;
    if (wr_phase) begin
      // Locked write half of fetch-and-increment; a snoop here is illegal
      ev_valid = 1'b1;
      ev_nxt   = ST_OEX;
      ev_lock  = 1'b1;
      ev_err   = snp_valid;
    end else if (take_snoop) begin
      ev_valid = (sop != BOP_NONE);
      ev_nxt   = xr.nxt;
      ev_sup   = xr.supply;
      ev_err   = xr.err;
    end else if (take_cpu) begin
      ev_valid = 1'b1;
      ev_op    = xr.op;
      ev_nxt   = xr.nxt;
      ev_lock  = (cop == CPU_FINC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req_valid <= 1'b0;
      bus_req_op    <= 3'd0;
      bus_lock      <= 1'b0;
      intervene     <= 1'b0;
      proto_err     <= 1'b0;
      upd_valid     <= 1'b0;
      upd_state     <= 3'd0;
      upd_line      <= '0;
    end else begin
      bus_req_valid <= ev_valid && (ev_op != BOP_NONE);
      bus_req_op    <= ev_valid ? ev_op : BOP_NONE;
      bus_lock      <= ev_valid && ev_lock;
      intervene     <= ev_valid && ev_sup;
      proto_err     <= ev_valid && ev_err;
      upd_valid     <= ev_valid;
      upd_state     <= ev_valid ? ev_nxt : ST_INV;
      upd_line      <= ev_valid ? ev_line : '0;
    end
  end

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req_valid,
  input logic [2:0] bus_req_op,
  input logic       bus_lock,
  input logic       intervene,
  input logic       proto_err,
  input logic [2:0] upd_state
);

  // R7: a supplying cache never ends in an exclusive state
  p_supply_not_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    intervene |-> (upd_state != 3'd1 && upd_state != 3'd2));

  // R14: snoop answers never start a bus operation
  p_snoop_no_issue_r14: assert property (@(posedge clk) disable iff (!rst_n)
    intervene |-> !bus_req_valid);

  // R5: an invalidate upgrade always lands in owned-exclusive
  p_upgrade_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_op == 3'd3) |-> upd_state == 3'd2);

  // R6: a write-back always leaves the line invalid
  p_wb_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_op == 3'd4) |-> upd_state == 3'd0);

  // R2: a coherent read fills clean
  p_read_fill_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_op == 3'd1) |-> (upd_state == 3'd1 || upd_state == 3'd3));

  // R12: the lock spans a second, quiet cycle ending owned-exclusive
  p_lock_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |=> (bus_lock && !bus_req_valid && upd_state == 3'd2));

  // R11: an illegal snoop produces no supply and no bus operation
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (!intervene && !bus_req_valid));

endmodule

bind coh_line_ctrl coh_line_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req_valid (bus_req_valid),
  .bus_req_op    (bus_req_op),
  .bus_lock      (bus_lock),
  .intervene     (intervene),
  .proto_err     (proto_err),
  .upd_state     (upd_state)
);

// File: tb/tb_coh_line_ctrl.sv
module tb_coh_line_ctrl;

  localparam int CLK_P = 10;
  localparam int NL    = 4;
  localparam int LW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          cpu_valid = 1'b0;
  logic [1:0]    cpu_op = '0;
  logic [LW-1:0] cpu_line = '0;
  logic          shared_hit = 1'b0;
  logic          snp_valid = 1'b0;
  logic [2:0]    snp_op = '0;
  logic [LW-1:0] snp_line = '0;

  logic rdy_a, bv_a, lk_a, iv_a, er_a, uv_a;
  logic [2:0] bo_a, us_a;
  logic [LW-1:0] ul_a;
  logic rdy_b, bv_b, lk_b, iv_b, er_b, uv_b;
  logic [2:0] bo_b, us_b;
  logic [LW-1:0] ul_b;

  coh_line_ctrl #(.NUM_LINES(NL), .HAS_COS(1'b1), .CE_SUPPLIES(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(rdy_a),
    .cpu_op(cpu_op), .cpu_line(cpu_line), .shared_hit(shared_hit),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_line(snp_line),
    .bus_req_valid(bv_a), .bus_req_op(bo_a), .bus_lock(lk_a), .intervene(iv_a),
    .proto_err(er_a), .upd_valid(uv_a), .upd_state(us_a), .upd_line(ul_a));

  coh_line_ctrl #(.NUM_LINES(NL), .HAS_COS(1'b0), .CE_SUPPLIES(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(rdy_b),
    .cpu_op(cpu_op), .cpu_line(cpu_line), .shared_hit(shared_hit),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_line(snp_line),
    .bus_req_valid(bv_b), .bus_req_op(bo_b), .bus_lock(lk_b), .intervene(iv_b),
    .proto_err(er_b), .upd_valid(uv_b), .upd_state(us_b), .upd_line(ul_b));

  wire [12:0] obs_a = {bv_a, bo_a, lk_a, iv_a, er_a, uv_a, us_a, ul_a};
  wire [12:0] obs_b = {bv_b, bo_b, lk_b, iv_b, er_b, uv_b, us_b, ul_b};

  int n_chk = 0;
  int n_fail = 0;
  int sa [NL];
  int sb [NL];
  bit finished = 1'b0;

  task automatic check(string req, bit ok, logic [12:0] act, logic [12:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [12:0] pack(bit bv, int bo, bit lk, bit iv, bit er, bit uv, int st, int ln);
    return {bv, 3'(bo), lk, iv, er, uv, 3'(st), LW'(ln)};
  endfunction

  // Expected behaviour from the requirement table
  function automatic void mdl(input bit cos, input bit ces, input bit snp, input int op,
                              input int st, input bit sh,
                              output int nx, output int bo, output bit sp, output bit er);
    nx = st; bo = 0; sp = 1'b0; er = 1'b0;
    if (!snp) begin
      case (op)
        0: if (st == 0) begin bo = 1; nx = sh ? 3 : 1; end
        1, 3: begin
          nx = 2;
          if (st == 0) bo = 2;
          else if (st >= 3) bo = (op == 3) ? 2 : 3;
        end
        default: begin nx = 0; if (st == 2 || st == 4) bo = 4; end
      endcase
    end else if (op == 5) begin
      nx = 0;
    end else begin
      case (st)
        1: case (op)
             1: begin nx = cos ? 5 : 3; sp = cos | ces; end
             2: begin nx = 0; sp = cos | ces; end
             default: er = 1'b1;
           endcase
        2: case (op)
             1: begin nx = 4; sp = 1'b1; end
             2: begin nx = 0; sp = 1'b1; end
             default: er = 1'b1;
           endcase
        3: if (op == 2 || op == 3) nx = 0;
        4, 5: case (op)
             1: sp = 1'b1;
             2: begin nx = 0; sp = 1'b1; end
             3: nx = 0;
             default: er = (st == 4);
           endcase
        default: nx = st;
      endcase
    end
  endfunction

  function automatic string tag_of(bit snp, int op, int st, bit er);
    if (!snp) begin
      if (op == 0) return (st == 0) ? "R2" : "R4";
      if (op == 1) return (st == 0) ? "R3" : ((st == 1 || st == 2) ? "R4" : "R5");
      if (op == 2) return "R6";
      return "R12";
    end
    if (er) return "R11";
    if (op == 5) return "R10";
    if (st == 0) return "R14";
    if (st == 1) return "R8";
    if (st == 2 || st == 4) return "R7";
    if (st == 5) return "R9";
    return "R10";
  endfunction

  task automatic step(bit snp, int op, int ln, bit sh);
    int nxa, boa, nxb, bob;
    bit spa, era, spb, erb;
    logic [12:0] ea, eb;
    string ta, tb;
    mdl(1'b1, 1'b0, snp, op, sa[ln], sh, nxa, boa, spa, era);
    mdl(1'b0, 1'b1, snp, op, sb[ln], sh, nxb, bob, spb, erb);
    ta = tag_of(snp, op, sa[ln], era);
    tb = tag_of(snp, op, sb[ln], erb);
    @(negedge clk);
    if (snp) begin
      snp_valid = 1'b1; snp_op = 3'(op); snp_line = LW'(ln);
    end else begin
      cpu_valid = 1'b1; cpu_op = 2'(op); cpu_line = LW'(ln); shared_hit = sh;
    end
    @(negedge clk);
    cpu_valid = 1'b0; snp_valid = 1'b0;
    ea = pack(!snp && boa != 0, boa, !snp && op == 3, spa, era, 1'b1, nxa, ln);
    eb = pack(!snp && bob != 0, bob, !snp && op == 3, spb, erb, 1'b1, nxb, ln);
    check(ta, obs_a == ea, obs_a, ea);
    check(tb, obs_b == eb, obs_b, eb);
    if (!snp && op == 3) begin
      check("R12", rdy_a == 1'b0, 13'(rdy_a), 13'd0);
      @(negedge clk);
      ea = pack(1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b1, 2, ln);
      check("R12", obs_a == ea, obs_a, ea);
      check("R12", obs_b == ea, obs_b, ea);
    end
    sa[ln] = nxa;
    sb[ln] = nxb;
  endtask

  task automatic setup(int s, int ln);
    step(1'b0, 2, ln, 1'b0);
    case (s)
      1: step(1'b0, 0, ln, 1'b0);
      2: step(1'b0, 1, ln, 1'b0);
      3: step(1'b0, 0, ln, 1'b1);
      4: begin step(1'b0, 1, ln, 1'b0); step(1'b1, 1, ln, 1'b0); end
      5: begin step(1'b0, 0, ln, 1'b0); step(1'b1, 1, ln, 1'b0); end
      default: ;
    endcase
  endtask

  initial begin
    logic [12:0] e;
    for (int i = 0; i < NL; i++) begin sa[i] = 0; sb[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", obs_a == 13'd0, obs_a, 13'd0);
    check("R1", obs_b == 13'd0, obs_b, 13'd0);
    check("R1", rdy_a && rdy_b, 13'({rdy_a, rdy_b}), 13'd3);
    step(1'b0, 0, 1, 1'b1); // first read of a reset line must fill (R1)

    // Sweep: every start state x every operation
    for (int s = 0; s < 6; s++) begin
      for (int ev = 0; ev < 9; ev++) begin
        int ln;
        ln = (s * 9 + ev) % NL;
        setup(s, ln);
        if (ev < 4) step(1'b0, ev, ln, 1'(ln));
        else        step(1'b1, ev - 3, ln, 1'b0);
      end
    end

    // R13: snoop wins over a simultaneous processor request
    step(1'b0, 2, 1, 1'b0);
    step(1'b0, 2, 2, 1'b0);
    step(1'b0, 1, 2, 1'b0);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd0; cpu_line = 2'd1; shared_hit = 1'b0;
    snp_valid = 1'b1; snp_op = 3'd1; snp_line = 2'd2;
    #1;
    check("R13", !rdy_a && !rdy_b, 13'({rdy_a, rdy_b}), 13'd0);
    @(negedge clk);
    e = pack(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b1, 4, 2);
    check("R13", obs_a == e, obs_a, e);
    check("R13", obs_b == e, obs_b, e);
    snp_valid = 1'b0;
    #1;
    check("R13", rdy_a && rdy_b, 13'({rdy_a, rdy_b}), 13'd3);
    @(negedge clk);
    cpu_valid = 1'b0;
    e = pack(1'b1, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1, 1);
    check("R13", obs_a == e, obs_a, e);
    check("R13", obs_b == e, obs_b, e);
    sa[2] = 4; sb[2] = 4; sa[1] = 1; sb[1] = 1;

    // R12: snoop during the locked write cycle is flagged and ignored
    step(1'b0, 2, 0, 1'b0);
    step(1'b0, 2, 3, 1'b0);
    step(1'b0, 1, 3, 1'b0);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd3; cpu_line = 2'd0;
    @(negedge clk);
    cpu_valid = 1'b0;
    e = pack(1'b1, 2, 1'b1, 1'b0, 1'b0, 1'b1, 2, 0);
    check("R12", obs_a == e, obs_a, e);
    check("R12", obs_b == e, obs_b, e);
    check("R12", !rdy_a && !rdy_b, 13'({rdy_a, rdy_b}), 13'd0);
    snp_valid = 1'b1; snp_op = 3'd1; snp_line = 2'd3;
    @(negedge clk);
    snp_valid = 1'b0;
    e = pack(1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b1, 2, 0);
    check("R12", obs_a == e, obs_a, e);
    check("R12", obs_b == e, obs_b, e);
    sa[0] = 2; sb[0] = 2;
    // line 3 must still be owned-exclusive: a write issues nothing
    step(1'b0, 1, 3, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule